// File: doc/BRIEF.md
# Keyed Function-Select Write Guard

This block holds an 8-bit function-select vector that chooses, per pin, between ordinary I/O and an alternate function. Software cannot change that vector freely. Two nested protections stand in front of it. A per-bit permission mask decides which select bits a write may touch. The mask itself can be rewritten only after a 32-bit key has been written to a lock register.

The key 0x0ACCE551 opens the lock. Writing any other value to the lock register closes it again. The lock never closes by itself. A permission-mask write made while the lock is closed is discarded, and a sticky flag records the refused attempt so that the refusal can be observed.

Every register is written on the clock edge that samples the write strobe. Reads are combinational from the address, with no wait states. The vector is driven straight out of the block to the pad multiplexing logic that sits next to it.

Top module: `pinmux_guard`

## Requirements
- R1: After reset the lock reads 1 (closed) at offset 0x520, the permission mask at 0x524 reads 0xFF, the select vector at 0x420 reads 0x00, and the refusal flag at 0x52C reads 0.
- R2: A write of exactly 0x0ACCE551 to 0x520 opens the lock, so that 0x520 reads 0 from the next cycle on.
- R3: A write of any other value to 0x520 closes the lock. The lock state changes only on writes to 0x520 and keeps its value for any number of idle cycles.
- R4: A write to 0x524 while the lock is open stores bits [7:0] of the write data as the permission mask. While the lock is closed, such a write leaves the mask unchanged.
- R5: A write to 0x420 changes exactly those select bits whose permission-mask bit is 1. Every other select bit keeps its value. The output `sel_out` always equals the value read at 0x420.
- R6: A write to 0x524 while the lock is closed sets the refusal flag (bit 0 at 0x52C). Any write to 0x52C clears the flag.
- R7: A write takes effect on the clock edge that samples `bus_wr`, with no wait states. A write to an unmapped offset changes no register, and a read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on each rising clock edge |
| bus_addr | input | 12 | Byte offset for both reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| sel_out | output | 8 | Current function-select vector |

## Verification
The in-module assertions check the following rules on every cycle:
- a closed lock freezes the permission mask;
- a select write leaves masked-off bits unchanged;
- the key always opens the lock;
- the lock moves only on lock-register writes;
- a refused commit always raises the flag.

Some behaviour only the bench scenarios can show. One is the exact readback values after sequences that open, close and reopen the lock. Another is that the lock stays open across a long idle stretch. A third is that unmapped writes leave every register and `sel_out` untouched.

// File: rtl/pinmux_guard.sv
module pinmux_guard #(
  parameter int          AW         = 12,
  parameter int          DW         = 32,
  parameter int          SW         = 8,
  parameter logic [31:0] KEY        = 32'h0ACC_E551,
  parameter logic [11:0] SEL_OFS    = 12'h420,
  parameter logic [11:0] LOCK_OFS   = 12'h520,
  parameter logic [11:0] COMMIT_OFS = 12'h524,
  parameter logic [11:0] FLAG_OFS   = 12'h52C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [SW-1:0] sel_out
);

  localparam logic [SW-1:0] ALL_ONES = {SW{1'b1}};

  logic          locked_q;
  logic          refused_q;
  logic [SW-1:0] commit_q;
  logic [SW-1:0] sel_q;

  wire hit_sel    = bus_addr == AW'(SEL_OFS);
  wire hit_lock   = bus_addr == AW'(LOCK_OFS);
  wire hit_commit = bus_addr == AW'(COMMIT_OFS);
  wire hit_flag   = bus_addr == AW'(FLAG_OFS);

  wire wr_sel    = bus_wr && hit_sel;
  wire wr_lock   = bus_wr && hit_lock;
  wire wr_commit = bus_wr && hit_commit;
  wire wr_flag   = bus_wr && hit_flag;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) locked_q <= 1'b1;
    else if (wr_lock) locked_q <= (bus_wdata != DW'(KEY));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) commit_q <= ALL_ONES;
    else if (wr_commit && !locked_q) commit_q <= bus_wdata[SW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sel_q <= '0;
    else if (wr_sel) sel_q <= (sel_q & ~commit_q) | (bus_wdata[SW-1:0] & commit_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) refused_q <= 1'b0;
    else if (wr_flag) refused_q <= 1'b0;
    else if (wr_commit && locked_q) refused_q <= 1'b1;

  always_comb begin
    bus_rdata = '0;
    if (hit_sel)         bus_rdata = DW'(sel_q);
    else if (hit_lock)   bus_rdata = DW'(locked_q);
    else if (hit_commit) bus_rdata = DW'(commit_q);
    else if (hit_flag)   bus_rdata = DW'(refused_q);
  end

  assign sel_out = sel_q;

  // R4
  commit_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && locked_q) |=> $stable(commit_q));

  // R5
  masked_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> ((sel_q & ~$past(commit_q)) == ($past(sel_q) & ~$past(commit_q))));

  // R2
  key_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lock && bus_wdata == DW'(KEY)) |=> !locked_q);

  // R3
  lock_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lock |=> $stable(locked_q));

  // R6
  refusal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && locked_q && !wr_flag) |=> refused_q);

endmodule

// File: tb/pinmux_guard_test.sv
module pinmux_guard_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  sel_out;

  pinmux_guard uut (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .sel_out);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [11:0] addr;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a;
    it.addr = a; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compares reads one quarter period after the edge that follows the request
  initial forever begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (bus_rdata !== it.exp) begin
        errors++;
        $display("FAIL %s addr %h actual %h expected %h", it.tag, it.addr, bus_rdata, it.exp);
      end
      if (it.addr == 12'h420) begin
        checks++;
        if (sel_out !== it.exp[7:0]) begin
          errors++;
          $display("FAIL R5 sel_out actual %h expected %h", sel_out, it.exp[7:0]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(12'h520, 32'h1, "R1 lock");
    rd(12'h524, 32'hFF, "R1 commit");
    rd(12'h420, 32'h0, "R1 sel");
    rd(12'h52C, 32'h0, "R1 flag");
    // R5 full mask after reset
    wr(12'h420, 32'hFFFF_FFA5);
    rd(12'h420, 32'hA5, "R5 full mask");
    // R4 / R6 locked commit write
    wr(12'h524, 32'h0F);
    rd(12'h524, 32'hFF, "R4 locked commit ignored");
    rd(12'h52C, 32'h1, "R6 flag set");
    wr(12'h52C, 32'h0);
    rd(12'h52C, 32'h0, "R6 flag cleared");
    // R2 unlock
    wr(12'h520, 32'h0ACC_E551);
    rd(12'h520, 32'h0, "R2 unlocked");
    // R3 no timeout
    repeat (100) @(negedge clk);
    rd(12'h520, 32'h0, "R3 still unlocked");
    // R4 unlocked commit write stores low byte
    wr(12'h524, 32'h1234_560F);
    rd(12'h524, 32'h0F, "R4 commit stored");
    rd(12'h52C, 32'h0, "R6 no flag when unlocked");
    // R5 partial mask
    wr(12'h420, 32'hFF);
    rd(12'h420, 32'hAF, "R5 partial set");
    wr(12'h420, 32'h00);
    rd(12'h420, 32'hA0, "R5 partial clear");
    // R3 near-key relocks
    wr(12'h520, 32'h0ACC_E550);
    rd(12'h520, 32'h1, "R3 relocked");
    wr(12'h524, 32'hFF);
    rd(12'h524, 32'h0F, "R4 relocked commit ignored");
    rd(12'h52C, 32'h1, "R6 flag set again");
    // R2 reopen, zero mask freezes selection
    wr(12'h520, 32'h0ACC_E551);
    rd(12'h520, 32'h0, "R2 reopened");
    wr(12'h524, 32'h0);
    wr(12'h420, 32'hFF);
    rd(12'h420, 32'hA0, "R5 zero mask");
    // R7 unmapped access
    wr(12'h600, 32'hFFFF_FFFF);
    rd(12'h600, 32'h0, "R7 unmapped read");
    rd(12'h420, 32'hA0, "R7 unmapped write sel");
    rd(12'h524, 32'h0, "R7 unmapped write commit");
    rd(12'h520, 32'h0, "R7 unmapped write lock");
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule